// File: doc/BRIEF.md
# Multi-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor that breaks every instruction into short clock steps. Holding registers sit between the steps: an instruction register, two operand registers, an ALU result register and a load data register. Each step is therefore only one slice of the work: fetch, operand read, execute or address calculation, memory access, or register write. A step controller decodes the opcode and sends each instruction class down its own path, so simple instructions retire in fewer cycles than loads.

Six instruction kinds are decoded: register-to-register arithmetic and logic, OR with an immediate, word load, word store, branch on equal, and an absolute jump. The main decoder drives a 3-bit ALU class code. A separate local ALU decoder turns that code, together with the function field, into the operation. Instruction and data memories are word-addressed arrays inside the block. A write port fills either memory, normally while the core is held in reset. Observation ports show the program counter, the fetch step, each register-file write and each store.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pc_o is 0, fetch_o is 1, and wb_valid_o and st_valid_o are 0.
- R2: Opcode 000000 writes register rd (bits 15:11) with the result of rs (bits 25:21) and rt (bits 20:16) chosen by the function field (bits 5:0). The codes are 100000 add, 100010 subtract, 100100 AND, 100101 OR and 101010 signed set-less-than. Any other code adds.
- R3: Opcode 001101 writes register rt with rs ORed with the zero-extended immediate in bits 15:0.
- R4: Opcode 100011 loads into rt the word at byte address rs plus the sign-extended immediate. Opcode 101011 stores rt at that address. Memory words are selected by address bits above bit 1.
- R5: Counted from one fetch step to the next, branch, jump and unrecognised opcodes take 3 cycles. Register-to-register, OR-immediate and store take 4 cycles, and load takes 5.
- R6: Opcode 000100 compares rs and rt by subtraction. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R7: Opcode 000010 sets the next PC to bits 31:28 of PC+4, followed by the 26-bit field in bits 25:0, followed by two zero bits.
- R8: Register 0 always reads as zero. A write to it is still reported on the write port but has no effect.
- R9: Any other opcode writes no register, stores nothing and advances the PC by 4.
- R10: wb_valid_o and st_valid_o are never high together. Each appears only in the final step of its instruction. fetch_o is high for exactly one cycle per instruction.
- R11: pc_o changes only on the edge that enters a fetch step, and it stays word aligned.
- R12: When load_we_i is high, load_data_i is written to word load_addr_i of the data memory if load_dmem_i is 1, or of the instruction memory if it is 0. A load-port write takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Memory fill write enable |
| load_dmem_i | input | 1 | Fill target: 1 data memory, 0 instruction memory |
| load_addr_i | input | LD_AW (6) | Fill word index |
| load_data_i | input | 32 | Fill data |
| pc_o | output | 32 | Program counter |
| fetch_o | output | 1 | Core is in the fetch step |
| wb_valid_o | output | 1 | Register-file write this cycle |
| wb_addr_o | output | 5 | Destination register |
| wb_data_o | output | 32 | Write data |
| st_valid_o | output | 1 | Data-memory store this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions check the step sequencing on every cycle. The gap between fetches must stay within 3 to 5 cycles. Write and store pulses must be exclusive and must come just before a fetch. The PC may move only into a fetch step and must stay word aligned. Arithmetic results, load data, address formation, branch decisions, jump targets and register-0 behaviour depend on the program. Only the bench's scenarios can show these: a scoreboard compares each write, store and fetch address, and each per-instruction cycle count, against values worked out by hand.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    AOP_ADD   = 3'b000,
    AOP_SUB   = 3'b001,
    AOP_OR    = 3'b010,
    AOP_FUNCT = 3'b100
  } aluop_e;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alufn_e;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_e;

  typedef struct packed {
    logic   reg_dst;
    logic   alu_src;
    logic   ext_op;
    logic   mem_to_reg;
    logic   mem_wr;
    logic   mem_acc;
    logic   reg_wr;
    logic   branch;
    logic   jump;
    aluop_e alu_op;
  } ctl_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [5:0]   opcode_i,
  output step_e        step_o,
  output ctl_t         ctl_o,
  output logic         last_o
);
  step_e step_q, step_d;
  ctl_t  ctl;

  always_comb begin
    ctl = '0;
    ctl.alu_op = AOP_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin ctl.reg_dst = 1'b1; ctl.reg_wr = 1'b1; ctl.alu_op = AOP_FUNCT; end
      OP_ORI:   begin ctl.alu_src = 1'b1; ctl.reg_wr = 1'b1; ctl.alu_op = AOP_OR; end
      OP_LW: begin
        ctl.alu_src = 1'b1; ctl.ext_op = 1'b1; ctl.mem_to_reg = 1'b1;
        ctl.mem_acc = 1'b1; ctl.reg_wr = 1'b1;
      end
      OP_SW: begin
        ctl.alu_src = 1'b1; ctl.ext_op = 1'b1; ctl.mem_wr = 1'b1; ctl.mem_acc = 1'b1;
      end
      OP_BEQ:   begin ctl.branch = 1'b1; ctl.alu_op = AOP_SUB; end
      OP_JMP:   ctl.jump = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    step_d = ST_FETCH;
    unique case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: step_d = ST_EXEC;
      ST_EXEC:   step_d = ctl.mem_acc ? ST_MEM : (ctl.reg_wr ? ST_WB : ST_FETCH);
      ST_MEM:    step_d = ctl.mem_to_reg ? ST_WB : ST_FETCH;
      default:   step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_FETCH;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
  assign ctl_o  = ctl;
  // final step of the instruction: the fetch step is never final
  assign last_o = (step_d == ST_FETCH) && (step_q != ST_FETCH);
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  aluop_e       alu_op_i,
  input  logic [5:0]   funct_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  alufn_e fn;

  // local decode: class code, or function field for register ops
  always_comb begin
    unique case (alu_op_i)
      AOP_SUB: fn = ALU_SUB;
      AOP_OR:  fn = ALU_OR;
      AOP_FUNCT: begin
        unique case (funct_i)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [NREG-1:0][W-1:0] q;

  assign q[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r <= '0;
      else if (we_i && waddr_i == AW'(i))   r <= wdata_i;
    end
    assign q[i] = r;
  end

  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6,
  localparam int unsigned LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_we_i,
  input  logic             load_dmem_i,
  input  logic [LD_AW-1:0] load_addr_i,
  input  logic [31:0]      load_data_i,
  output logic [31:0]      pc_o,
  output logic             fetch_o,
  output logic             wb_valid_o,
  output logic [4:0]       wb_addr_o,
  output logic [31:0]      wb_data_o,
  output logic             st_valid_o,
  output logic [31:0]      st_addr_o,
  output logic [31:0]      st_data_o
);
  localparam int unsigned IMEM_WORDS = 1 << IMEM_AW;
  localparam int unsigned DMEM_WORDS = 1 << DMEM_AW;

  step_e step;
  ctl_t  ctl;
  logic  last;

  logic [31:0] pc_q, ir_q, a_q, b_q, r_q, m_q;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic [31:0] imm_ext, alu_b, alu_y, rf_a, rf_b;
  logic [31:0] pc4, br_tgt, jmp_tgt, npc;
  logic        alu_zero, wb_fire, st_fire;

  assign rs  = ir_q[25:21];
  assign rt  = ir_q[20:16];
  assign rd  = ir_q[15:11];
  assign imm = ir_q[15:0];

  mc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[31:26]),
    .step_o   (step),
    .ctl_o    (ctl),
    .last_o   (last)
  );

  assign imm_ext = ctl.ext_op ? {{16{imm[15]}}, imm} : {16'b0, imm};
  assign alu_b   = ctl.alu_src ? imm_ext : b_q;

  mc_alu #(.W(32)) u_alu (
    .alu_op_i (ctl.alu_op),
    .funct_i  (ir_q[5:0]),
    .a_i      (a_q),
    .b_i      (alu_b),
    .y_o      (alu_y),
    .zero_o   (alu_zero)
  );

  assign wb_fire = (step == ST_WB);
  assign st_fire = (step == ST_MEM) && ctl.mem_wr;

  mc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_fire),
    .waddr_i   (wb_addr_o),
    .wdata_i   (wb_data_o),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b)
  );

  // next PC
  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + {{14{imm[15]}}, imm, 2'b00};
  assign jmp_tgt = {pc4[31:28], ir_q[25:0], 2'b00};
  assign npc     = ctl.jump ? jmp_tgt : ((ctl.branch && alu_zero) ? br_tgt : pc4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; ir_q <= '0; a_q <= '0; b_q <= '0; r_q <= '0; m_q <= '0;
    end else begin
      unique case (step)
        ST_FETCH:  ir_q <= imem[pc_q[IMEM_AW+1:2]];
        ST_DECODE: begin a_q <= rf_a; b_q <= rf_b; end
        ST_EXEC:   r_q <= alu_y;
        ST_MEM:    if (ctl.mem_to_reg) m_q <= dmem[r_q[DMEM_AW+1:2]];
        default:   ;
      endcase
      if (last) pc_q <= npc;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_we_i && !load_dmem_i) imem[load_addr_i[IMEM_AW-1:0]] <= load_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (load_we_i && load_dmem_i) dmem[load_addr_i[DMEM_AW-1:0]] <= load_data_i;
    else if (st_fire)             dmem[r_q[DMEM_AW+1:2]] <= b_q;
  end

  assign pc_o       = pc_q;
  assign fetch_o    = (step == ST_FETCH);
  assign wb_valid_o = wb_fire;
  assign wb_addr_o  = ctl.reg_dst ? rd : rt;
  assign wb_data_o  = ctl.mem_to_reg ? m_q : r_q;
  assign st_valid_o = st_fire;
  assign st_addr_o  = r_q;
  assign st_data_o  = b_q;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic        fetch_o,
  input logic        wb_valid_o,
  input logic        st_valid_o
);
  logic [2:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (fetch_o)       gap_q <= 3'd1;
    else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  // R5
  step_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_o |-> (gap_q <= 3'd4));
  // R5
  step_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && gap_q != 3'd0) |-> (gap_q >= 3'd3));
  // R10
  no_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_valid_o && st_valid_o));
  // R10
  wb_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> fetch_o);
  // R10
  st_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |=> fetch_o);
  // R10
  fetch_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o);
  // R11
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_o |-> $stable(pc_o));
  // R11
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_o       (pc_o),
  .fetch_o    (fetch_o),
  .wb_valid_o (wb_valid_o),
  .st_valid_o (st_valid_o)
);

// File: tb/mc_core_bench.sv
`timescale 1ns/1ps
module mc_core_bench;
  localparam int LIMIT = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_we_i = 1'b0;
  logic        load_dmem_i = 1'b0;
  logic [5:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        fetch_o, wb_valid_o, st_valid_o;
  logic [4:0]  wb_addr_o;

  mc_core u_mc_core (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int          kind;   // 0 fetch, 1 write-back, 2 store
    logic [31:0] a;
    logic [31:0] d;
    int          steps;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, gap = 0;
  bit done = 1'b0;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic exp_fetch(logic [31:0] pc, int steps, string req);
    q.push_back('{0, pc, 32'h0, steps, req});
  endtask
  task automatic exp_wb(logic [31:0] a, logic [31:0] d, string req);
    q.push_back('{1, a, d, 0, req});
  endtask
  task automatic exp_st(logic [31:0] a, logic [31:0] d, string req);
    q.push_back('{2, a, d, 0, req});
  endtask

  task automatic load(bit dm, int addr, logic [31:0] data);
    @(negedge clk_i);
    load_we_i = 1'b1; load_dmem_i = dm; load_addr_i = addr[5:0]; load_data_i = data;
    @(negedge clk_i);
    load_we_i = 1'b0;
  endtask

  task automatic take(int kind, logic [31:0] a, logic [31:0] d);
    item_t it;
    if (q.size() == 0) begin
      chk("R10", "unexpected event kind", kind, 32'hffffffff);
      return;
    end
    it = q.pop_front();
    chk(it.req, "event kind", kind, it.kind);
    if (kind == it.kind) begin
      if (kind == 0) begin
        chk(it.req, "fetch pc", a, it.a);
        if (it.steps != 0) chk("R5", "step count", gap, it.steps);
      end else begin
        chk(it.req, (kind == 1) ? "wb addr" : "st addr", a, it.a);
        chk(it.req, (kind == 1) ? "wb data" : "st data", d, it.d);
      end
    end
    if (q.size() == 0) done = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (fetch_o) begin
        take(0, pc_o, 32'h0);
        gap = 1;
      end else begin
        gap++;
      end
      if (wb_valid_o) take(1, {27'b0, wb_addr_o}, wb_data_o);
      if (st_valid_o) take(2, st_addr_o, st_data_o);
    end
  end

  initial begin
    logic [31:0] prog [26];
    prog[0]  = enc_i(6'b001101, 0, 1, 16'h1234);      // ori r1
    prog[1]  = enc_i(6'b001101, 0, 2, 16'h8001);      // ori r2
    prog[2]  = enc_r(1, 2, 3, 6'h20);                 // add
    prog[3]  = enc_r(1, 2, 4, 6'h22);                 // sub
    prog[4]  = enc_r(4, 3, 5, 6'h24);                 // and
    prog[5]  = enc_r(1, 2, 6, 6'h25);                 // or
    prog[6]  = enc_r(4, 1, 7, 6'h2a);                 // slt true
    prog[7]  = enc_r(1, 4, 8, 6'h2a);                 // slt false
    prog[8]  = enc_i(6'b101011, 0, 3, 16'h0008);      // sw r3,8(r0)
    prog[9]  = enc_i(6'b001101, 0, 9, 16'h0010);      // ori r9
    prog[10] = enc_i(6'b101011, 9, 4, 16'hfffc);      // sw r4,-4(r9)
    prog[11] = enc_i(6'b100011, 9, 10, 16'hfff8);     // lw r10,-8(r9)
    prog[12] = enc_i(6'b100011, 0, 11, 16'h000c);     // lw r11,12(r0)
    prog[13] = enc_i(6'b100011, 0, 14, 16'h0014);     // lw preloaded
    prog[14] = enc_i(6'b001101, 0, 0, 16'h0055);      // ori r0
    prog[15] = enc_r(0, 1, 12, 6'h20);                // add r12,r0,r1
    prog[16] = enc_i(6'b000100, 1, 2, 16'h0005);      // beq not taken
    prog[17] = enc_i(6'b000100, 3, 10, 16'h0002);     // beq taken
    prog[18] = enc_i(6'b001101, 0, 13, 16'hdead);
    prog[19] = enc_i(6'b001101, 0, 13, 16'hdead);
    prog[20] = 32'hfc00_0000;                         // unrecognised
    prog[21] = {6'b000010, 26'd25};                   // jump
    prog[22] = enc_i(6'b001101, 0, 13, 16'hdead);
    prog[23] = enc_i(6'b001101, 0, 13, 16'hdead);
    prog[24] = enc_i(6'b001101, 0, 13, 16'hdead);
    prog[25] = enc_i(6'b000100, 0, 0, 16'hffff);      // beq to itself

    // R12: fill through the load port while held in reset
    for (int i = 0; i < 26; i++) load(1'b0, i, prog[i]);
    load(1'b1, 5, 32'hcafe_f00d);

    // R1: reset state
    @(negedge clk_i);
    chk("R1", "pc in reset", pc_o, 32'h0);
    chk("R1", "fetch in reset", {31'b0, fetch_o}, 32'h1);
    chk("R1", "wb in reset", {31'b0, wb_valid_o}, 32'h0);
    chk("R1", "st in reset", {31'b0, st_valid_o}, 32'h0);

    exp_fetch(32'h00, 0, "R1");
    exp_wb(1, 32'h0000_1234, "R3");        exp_fetch(32'h04, 4, "R3");
    exp_wb(2, 32'h0000_8001, "R3");        exp_fetch(32'h08, 4, "R3");
    exp_wb(3, 32'h0000_9235, "R2");        exp_fetch(32'h0c, 4, "R2");
    exp_wb(4, 32'hffff_9233, "R2");        exp_fetch(32'h10, 4, "R2");
    exp_wb(5, 32'h0000_9231, "R2");        exp_fetch(32'h14, 4, "R2");
    exp_wb(6, 32'h0000_9235, "R2");        exp_fetch(32'h18, 4, "R2");
    exp_wb(7, 32'h0000_0001, "R2");        exp_fetch(32'h1c, 4, "R2");
    exp_wb(8, 32'h0000_0000, "R2");        exp_fetch(32'h20, 4, "R2");
    exp_st(32'h08, 32'h0000_9235, "R4");   exp_fetch(32'h24, 4, "R4");
    exp_wb(9, 32'h0000_0010, "R3");        exp_fetch(32'h28, 4, "R3");
    exp_st(32'h0c, 32'hffff_9233, "R4");   exp_fetch(32'h2c, 4, "R4");
    exp_wb(10, 32'h0000_9235, "R4");       exp_fetch(32'h30, 5, "R4");
    exp_wb(11, 32'hffff_9233, "R4");       exp_fetch(32'h34, 5, "R4");
    exp_wb(14, 32'hcafe_f00d, "R12");      exp_fetch(32'h38, 5, "R12");
    exp_wb(0, 32'h0000_0055, "R8");        exp_fetch(32'h3c, 4, "R8");
    exp_wb(12, 32'h0000_1234, "R8");       exp_fetch(32'h40, 4, "R8");
    exp_fetch(32'h44, 3, "R6");
    exp_fetch(32'h50, 3, "R6");
    exp_fetch(32'h54, 3, "R9");
    exp_fetch(32'h64, 3, "R7");
    exp_fetch(32'h64, 3, "R6");
    exp_fetch(32'h64, 3, "R6");

    rst_ni = 1'b1;
    // R1: first cycle after reset release
    chk("R1", "pc after release", pc_o, 32'h0);

    while (!done && cyc < LIMIT) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles exp completion, %0d items left", cyc, q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule